// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits in front of a small on-chip flash array and turns register writes on a 32-bit bus into erase and program operations. The array is held inside the block as four 32-bit lanes of page-organised storage. A bit can be cleared by programming, and only an erase sets bits back to one. Software loads a target address, a clock divider, up to four data words and a protection bitmap. It then writes the control register with an unlock key, an erase qualifier, a width selection and one start bit.

The block checks each start request in the cycle it is written. A valid request raises a pending indication for a time that software can predict. At the end of that time the array is updated, and the start bits and qualifier are cleared. A request that is locked, badly qualified, misaligned, malformed or aimed at protected storage is refused at once. The array is not touched, and a sticky access-fault flag is raised. A side read port lets the array contents be inspected while the block is idle.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, every register reads 0, `busy_o` is 0 and the access-fault flag is 0. The array powers up erased, with every word equal to 0xFFFFFFFF.
- R2: The register offsets are: address 0x000 (bits 8:0 kept), divider 0x004 (bits 7:0 kept), control 0x008, status 0x024, data words 0x030/0x034/0x038/0x03C, and protection 0x300 (one bit per page, bit n = page n, 8 pages kept). Each register reads back what was written, limited to its kept bits.
- R3: A start request is refused unless control bits 31:28 of the written value equal 0x2. A refused request leaves the array unchanged, never raises pending, and sets the fault flag (status bit 1).
- R4: A page erase (control bit 2) needs qualifier bits 15:8 = 0x55. A mass erase (control bit 1) needs qualifier 0xAA. Any other qualifier makes the request a refused request.
- R5: Pending (control bit 24 and `busy_o`) is 1 for exactly (divider+1)*40 cycles, starting in the cycle after the accepted control write.
- R6: When pending falls, control bits 2:0 and 15:8 read 0. The key (31:28) and the width bits (27 and 4) keep their values.
- R7: A program request (bit 0) with bit 4 set stores (old AND data word 0) into the word at address bits 8:2. No other word changes, so a second program cannot set a 0 bit back to 1.
- R8: A program request with bit 27 set stores (old AND data word k) into the four words starting at the address. It needs address bits 3:2 = 0, and is refused otherwise.
- R9: A page erase sets every word of the 64-byte page containing the address to 0xFFFFFFFF and leaves every other page unchanged.
- R10: A mass erase sets all 128 words to 0xFFFFFFFF. It is refused while any protection bit is set.
- R11: A page erase or a program request aimed at a page whose protection bit is 1 is refused.
- R12: The fault flag stays set through later successful operations. Writing the status register with bit 1 = 0 clears it, and writing bit 1 = 1 leaves it unchanged.
- R13: While pending is 1, bus writes to the address, divider, control, data and protection registers have no effect.
- R14: A request with more than one start bit set, or a program request with both or neither of bits 27 and 4, is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| arr_raddr | input | 7 | Word index for the array inspection port |
| arr_rdata | output | 32 | Array word, valid the cycle after `arr_raddr` is applied while idle |
| busy_o | output | 1 | Operation pending |

## Verification
Programming is tried on erased words and then again on already-programmed words. The second pass shows whether new data is ANDed with the old word or simply replaces it. Wide programming is tried at an aligned address and at a misaligned one.

Page erase uses an address in the middle of a page, with programmed words both inside and outside that page. This separates a page-wide erase from a single-word erase and from an erase of the wrong page. Each refusal cause is applied on its own: missing key, wrong qualifier, protection, two start bits, and a bad width selection. After each one the target word and the pending line are checked, so a refusal that still changed storage is caught. Pending length is measured with two divider values, which separates a divided tick from a plain cycle count.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PAGE, OP_MASS, OP_PROG} op_e;

  localparam logic [11:0] OFS_ADDR = 12'h000;
  localparam logic [11:0] OFS_DIV  = 12'h004;
  localparam logic [11:0] OFS_CTRL = 12'h008;
  localparam logic [11:0] OFS_STAT = 12'h024;
  localparam logic [11:0] OFS_DAT0 = 12'h030;
  localparam logic [11:0] OFS_PROT = 12'h300;

  localparam logic [3:0] KEY_OPEN  = 4'h2;
  localparam logic [7:0] QUAL_PAGE = 8'h55;
  localparam logic [7:0] QUAL_MASS = 8'hAA;
endpackage

// File: rtl/flash_lane_mem.sv
module flash_lane_mem #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  // erased state at power-up
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_tick_timer.sv
module flash_tick_timer #(
  parameter int DIV_W    = 8,
  parameter int OP_TICKS = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             done
);
  localparam int TW = $clog2(OP_TICKS + 1);

  logic [DIV_W-1:0] pre_q;
  logic [TW-1:0]    tk_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      pre_q <= '0;
      tk_q  <= '0;
    end else if (run && tk_q != TW'(OP_TICKS)) begin
      if (pre_q == div) begin
        pre_q <= '0;
        tk_q  <= tk_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign done = run && ((tk_q == TW'(OP_TICKS)) ||
                        (pre_q == div && tk_q == TW'(OP_TICKS - 1)));

  a_r5_tick_in_range: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && !load |-> tk_q <= TW'(OP_TICKS));
endmodule

// File: rtl/flash_cmd_check.sv
module flash_cmd_check
  import flash_cmd_pkg::*;
#(
  parameter int PAGES  = 8,
  parameter int PAGE_W = 3
) (
  input  logic [2:0]        start,
  input  logic [3:0]        key,
  input  logic [7:0]        qual,
  input  logic              w32,
  input  logic              w128,
  input  logic [1:0]        word_in_row,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGES-1:0]  prot,
  output logic              req,
  output logic              accept,
  output op_e               op
);
  logic key_ok;
  assign key_ok = (key == KEY_OPEN);
  assign req    = |start;

  always_comb begin
    op     = OP_NONE;
    accept = 1'b0;
    unique case (start)
      3'b100: begin
        op     = OP_PAGE;
        accept = key_ok && qual == QUAL_PAGE && !prot[page];
      end
      3'b010: begin
        op     = OP_MASS;
        accept = key_ok && qual == QUAL_MASS && prot == '0;
      end
      3'b001: begin
        op     = OP_PROG;
        accept = key_ok && (w32 ^ w128) && (!w128 || word_in_row == 2'b00) && !prot[page];
      end
      default: begin
        op     = OP_NONE;
        accept = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int PAGES          = 8,
  parameter int WORDS_PER_PAGE = 16,
  parameter int DIV_W          = 8,
  parameter int OP_TICKS       = 40,
  localparam int WORDS         = PAGES * WORDS_PER_PAGE,
  localparam int WIDX_W        = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [WIDX_W-1:0] arr_raddr,
  output logic [31:0]       arr_rdata,
  output logic              busy_o
);
  localparam int LANES      = 4;
  localparam int ROWS       = WORDS / LANES;
  localparam int RPP        = WORDS_PER_PAGE / LANES;
  localparam int ADDR_W     = $clog2(WORDS * 4);
  localparam int ROW_W      = $clog2(ROWS);
  localparam int PB         = $clog2(WORDS_PER_PAGE * 4);
  localparam int PAGE_W     = $clog2(PAGES);
  localparam int PROT_WORDS = (PAGES + 31) / 32;

  // register state
  logic [ADDR_W-1:0] addr_q;
  logic [DIV_W-1:0]  div_q;
  logic [3:0]        key_q;
  logic              w128_q, w32_q;
  logic [7:0]        qual_q;
  logic [2:0]        start_q;
  logic              pend_q, fault_q;
  logic [31:0]       data_q [LANES];
  logic [PAGES-1:0]  prot_q;

  // operation state
  op_e               op_q;
  logic [ROW_W-1:0]  row_q, last_q;
  logic [1:0]        plane_q, rlane_q;
  logic              walk_done_q;

  logic              wr, wr_ctrl, wr_stat, idle_wr;
  logic              req, accept, tdone, fin;
  op_e               op_new;
  logic [PAGE_W-1:0] cur_page;
  logic [ROW_W-1:0]  page_row;

  assign wr       = bus_en && bus_we;
  assign wr_ctrl  = wr && bus_addr == OFS_CTRL;
  assign wr_stat  = wr && bus_addr == OFS_STAT;
  assign idle_wr  = wr && !pend_q;
  assign cur_page = addr_q[ADDR_W-1:PB];
  assign page_row = ROW_W'(cur_page) * ROW_W'(RPP);

  flash_cmd_check #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_check (
    .start       (bus_wdata[2:0]),
    .key         (bus_wdata[31:28]),
    .qual        (bus_wdata[15:8]),
    .w32         (bus_wdata[4]),
    .w128        (bus_wdata[27]),
    .word_in_row (addr_q[3:2]),
    .page        (cur_page),
    .prot        (prot_q),
    .req         (req),
    .accept      (accept),
    .op          (op_new)
  );

  logic start_ok, start_bad;
  assign start_ok  = wr_ctrl && !pend_q && req && accept;
  assign start_bad = wr_ctrl && !pend_q && req && !accept;

  flash_tick_timer #(.DIV_W(DIV_W), .OP_TICKS(OP_TICKS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (start_ok),
    .run  (pend_q),
    .div  (div_q),
    .done (tdone)
  );

  assign fin = pend_q && tdone && (op_q == OP_PROG || walk_done_q);

  // control, status and sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0; w128_q <= 1'b0; w32_q <= 1'b0; qual_q <= '0; start_q <= '0;
      pend_q <= 1'b0; fault_q <= 1'b0; op_q <= OP_NONE;
      row_q <= '0; last_q <= '0; plane_q <= '0; walk_done_q <= 1'b0;
    end else begin
      if (wr_stat && !bus_wdata[1]) fault_q <= 1'b0;
      if (wr_ctrl && !pend_q) begin
        key_q  <= bus_wdata[31:28];
        w128_q <= bus_wdata[27];
        w32_q  <= bus_wdata[4];
        if (start_bad) begin
          qual_q  <= '0;
          start_q <= '0;
          fault_q <= 1'b1;
        end else begin
          qual_q  <= bus_wdata[15:8];
          start_q <= bus_wdata[2:0];
        end
      end
      if (start_ok) begin
        pend_q      <= 1'b1;
        op_q        <= op_new;
        walk_done_q <= 1'b0;
        plane_q     <= addr_q[3:2];
        case (op_new)
          OP_PAGE: begin row_q <= page_row; last_q <= page_row + ROW_W'(RPP - 1); end
          OP_MASS: begin row_q <= '0;       last_q <= ROW_W'(ROWS - 1);           end
          default: begin row_q <= addr_q[ADDR_W-1:4]; last_q <= addr_q[ADDR_W-1:4]; end
        endcase
      end else if (pend_q) begin
        if ((op_q == OP_PAGE || op_q == OP_MASS) && !walk_done_q) begin
          if (row_q == last_q) walk_done_q <= 1'b1;
          else                 row_q <= row_q + 1'b1;
        end
        if (fin) begin
          pend_q  <= 1'b0;
          start_q <= '0;
          qual_q  <= '0;
          op_q    <= OP_NONE;
        end
      end
    end
  end

  // plain registers, frozen while pending
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      div_q  <= '0;
      prot_q <= '0;
      for (int l = 0; l < LANES; l++) data_q[l] <= '0;
    end else if (idle_wr) begin
      if (bus_addr == OFS_ADDR) addr_q <= bus_wdata[ADDR_W-1:0];
      if (bus_addr == OFS_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
      for (int l = 0; l < LANES; l++)
        if (bus_addr == OFS_DAT0 + 12'(4 * l)) data_q[l] <= bus_wdata;
      for (int p = 0; p < PAGES; p++)
        if (bus_addr == OFS_PROT + 12'(4 * (p / 32))) prot_q[p] <= bus_wdata[p % 32];
    end
  end

  // array lanes
  logic             erase_we, prog_fin;
  logic [ROW_W-1:0] mem_raddr;
  logic [31:0]      rdq [LANES];

  assign erase_we  = pend_q && (op_q == OP_PAGE || op_q == OP_MASS) && !walk_done_q;
  assign prog_fin  = fin && op_q == OP_PROG;
  assign mem_raddr = pend_q ? row_q : arr_raddr[WIDX_W-1:2];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic        lwe;
    logic [31:0] lwdata;
    assign lwe    = erase_we || (prog_fin && (w128_q || plane_q == 2'(l)));
    assign lwdata = erase_we ? '1 : (rdq[l] & (w128_q ? data_q[l] : data_q[0]));
    flash_lane_mem #(.DEPTH(ROWS), .AW(ROW_W)) u_mem (
      .clk   (clk),
      .we    (lwe),
      .waddr (row_q),
      .wdata (lwdata),
      .raddr (mem_raddr),
      .rdata (rdq[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rlane_q <= '0;
    else     rlane_q <= arr_raddr[1:0];
  end
  assign arr_rdata = rdq[rlane_q];
  assign busy_o    = pend_q;

  // register read mux
  logic [31:0] prot_word [PROT_WORDS];
  always_comb begin
    for (int w = 0; w < PROT_WORDS; w++) prot_word[w] = '0;
    for (int p = 0; p < PAGES; p++) prot_word[p / 32][p % 32] = prot_q[p];
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_ADDR: rd_mux = 32'(addr_q);
      OFS_DIV:  rd_mux = 32'(div_q);
      OFS_CTRL: rd_mux = {key_q, w128_q, 2'b00, pend_q, 8'h00, qual_q, 3'b000, w32_q, 1'b0, start_q};
      OFS_STAT: rd_mux = {30'd0, fault_q, 1'b0};
      default: begin
        for (int l = 0; l < LANES; l++)
          if (bus_addr == OFS_DAT0 + 12'(4 * l)) rd_mux = data_q[l];
        for (int w = 0; w < PROT_WORDS; w++)
          if (bus_addr == OFS_PROT + 12'(4 * w)) rd_mux = prot_word[w];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                   bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_mux;
  end

  // checks
  logic [31:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst)         chk_cnt <= '0;
    else if (pend_q) chk_cnt <= chk_cnt + 1;
    else             chk_cnt <= '0;
  end

  a_r3_key_open: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> key_q == KEY_OPEN);
  a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> chk_cnt == (32'(div_q) + 1) * OP_TICKS);
  a_r6_self_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> start_q == 3'b000 && qual_q == 8'h00);
  a_r10_mass_unprot: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) && op_q == OP_MASS |-> prot_q == '0);
  a_r11_page_unprot: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) && op_q != OP_MASS |-> !prot_q[cur_page]);
  a_r12_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    fault_q && !(wr_stat && !bus_wdata[1]) |=> fault_q);
  a_r13_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> $stable(addr_q) && $stable(prot_q));
endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  localparam int WORDS = 128;
  localparam int TICKS = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  arr_raddr = '0;
  logic [31:0] arr_rdata;
  logic        busy_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [WORDS];

  always #4 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_raddr(arr_raddr),
    .arr_rdata(arr_rdata), .busy_o(busy_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_en = 1'b0;
  endtask

  task automatic arr_read(input int idx, output logic [31:0] d);
    arr_raddr = 7'(idx);
    @(posedge clk); @(negedge clk);
    d = arr_rdata;
  endtask

  task automatic start_op(input logic [31:0] ctrl, output int n);
    bus_write(12'h008, ctrl);
    n = 0;
    while (busy_o && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic check_word(input string tag, input int idx);
    logic [31:0] d;
    arr_read(idx, d);
    check(tag, d, model[idx]);
  endtask

  task automatic check_fault(input string tag, input logic exp);
    logic [31:0] d;
    bus_read(12'h024, d);
    check(tag, d, {30'd0, exp, 1'b0});
  endtask

  task automatic clear_fault();
    bus_write(12'h024, 32'h0);
  endtask

  task automatic prog32(input int word, input logic [31:0] val, input string tag);
    int n;
    bus_write(12'h000, 32'(word * 4));
    bus_write(12'h030, val);
    start_op(32'h2000_0011, n);
    model[word] = model[word] & val;
    check(tag, 32'(n), 32'(TICKS));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 busy", {31'd0, busy_o}, 32'h0);
    bus_read(12'h008, d); check("R1 ctrl", d, 32'h0);
    bus_read(12'h000, d); check("R1 addr", d, 32'h0);
    bus_read(12'h300, d); check("R1 prot", d, 32'h0);
    check_fault("R1 fault", 1'b0);
    check_word("R1 erased", 5);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(12'h000, 32'hFFFF_FFFF); bus_read(12'h000, d); check("R2 addr mask", d, 32'h1FF);
    bus_write(12'h004, 32'h0000_0103); bus_read(12'h004, d); check("R2 div", d, 32'h03);
    bus_write(12'h004, 32'h0);
    for (int k = 0; k < 4; k++) begin
      bus_write(12'h030 + 12'(4 * k), 32'hC0DE_0000 + 32'(k));
      bus_read(12'h030 + 12'(4 * k), d); check("R2 data", d, 32'hC0DE_0000 + 32'(k));
    end
    bus_write(12'h300, 32'hFFFF_FF05); bus_read(12'h300, d); check("R2 prot", d, 32'h05);
    bus_write(12'h300, 32'h0);
  endtask

  task automatic t_prog32();
    logic [31:0] d;
    prog32(18, 32'h1234_5678, "R5 pending length div0");
    check_word("R7 first program", 18);
    check_word("R7 neighbour", 19);
    bus_read(12'h008, d); check("R6 ctrl after program", d, 32'h2000_0010);
    prog32(18, 32'hFF00_FF00, "R5 pending length");
    check_word("R7 AND with old", 18);
    check_fault("R7 no fault", 1'b0);
  endtask

  task automatic t_prog128();
    int n;
    bus_write(12'h000, 32'h080);
    for (int k = 0; k < 4; k++) bus_write(12'h030 + 12'(4 * k), 32'hA000_0000 | 32'(k * 17));
    start_op(32'h2800_0001, n);
    for (int k = 0; k < 4; k++) begin
      model[32 + k] = 32'hA000_0000 | 32'(k * 17);
      check_word("R8 wide program", 32 + k);
    end
    bus_write(12'h000, 32'h0C4);
    start_op(32'h2800_0001, n);
    check("R8 misaligned no pending", 32'(n), 32'h0);
    check_word("R8 misaligned unchanged", 49);
    check_fault("R8 misaligned fault", 1'b1);
    clear_fault();
  endtask

  task automatic t_page_erase();
    int n;
    logic [31:0] d;
    bus_write(12'h004, 32'h2);
    bus_write(12'h000, 32'h050);
    bus_write(12'h008, 32'h2000_5500);
    start_op(32'h2000_5504, n);
    check("R5 pending length div2", 32'(n), 32'(3 * TICKS));
    bus_write(12'h004, 32'h0);
    for (int w = 16; w < 32; w++) model[w] = '1;
    check_word("R9 page erased", 18);
    check_word("R9 page start", 16);
    check_word("R9 page end", 31);
    check_word("R9 next page kept", 32);
    bus_read(12'h008, d); check("R6 qualifier cleared", d, 32'h2000_0000);
  endtask

  task automatic t_qual();
    int n;
    logic [31:0] d;
    bus_write(12'h000, 32'h080);
    start_op(32'h2000_AA04, n);
    check("R4 wrong qualifier no pending", 32'(n), 32'h0);
    check_word("R4 wrong qualifier unchanged", 32);
    check_fault("R4 fault", 1'b1);
    start_op(32'h2000_5502, n);
    check("R4 mass with page qualifier", 32'(n), 32'h0);
    check_word("R4 mass refused", 33);
    prog32(60, 32'h0000_FFFF, "R12 pending");
    check_fault("R12 sticky across success", 1'b1);
    bus_write(12'h024, 32'h2);
    check_fault("R12 write one keeps", 1'b1);
    clear_fault();
    check_fault("R12 write zero clears", 1'b0);
    bus_read(12'h008, d); check("R6 key kept", d[31:28], 32'h2);
  endtask

  task automatic t_locked();
    int n;
    bus_write(12'h000, 32'h0A0);
    bus_write(12'h030, 32'h0);
    start_op(32'h0000_0011, n);
    check("R3 locked no pending", 32'(n), 32'h0);
    check_word("R3 locked unchanged", 40);
    check_fault("R3 fault", 1'b1);
    clear_fault();
  endtask

  task automatic t_protect();
    int n;
    bus_write(12'h300, 32'h4);
    bus_write(12'h000, 32'h080);
    start_op(32'h2000_5504, n);
    check("R11 erase protected", 32'(n), 32'h0);
    check_word("R11 erase protected unchanged", 32);
    check_fault("R11 fault", 1'b1);
    clear_fault();
    bus_write(12'h000, 32'h0A0);
    bus_write(12'h030, 32'h0);
    start_op(32'h2000_0011, n);
    check_word("R11 program protected unchanged", 40);
    check_fault("R11 fault program", 1'b1);
    clear_fault();
    start_op(32'h2000_AA02, n);
    check("R10 mass refused when protected", 32'(n), 32'h0);
    check_word("R10 mass refused unchanged", 18);
    check_fault("R10 fault", 1'b1);
    clear_fault();
    prog32(48, 32'hA5A5_A5A5, "R11 unprotected page pending");
    check_word("R11 unprotected page", 48);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    bus_write(12'h000, 32'h0C8);
    bus_write(12'h030, 32'h0F0F_0F0F);
    bus_write(12'h008, 32'h2000_0011);
    bus_write(12'h000, 32'h100);
    bus_write(12'h030, 32'h0);
    bus_write(12'h004, 32'h7);
    bus_write(12'h300, 32'hFF);
    bus_write(12'h008, 32'h0);
    while (busy_o) @(negedge clk);
    model[50] = model[50] & 32'h0F0F_0F0F;
    check_word("R13 data used", 50);
    bus_read(12'h000, d); check("R13 addr kept", d, 32'h0C8);
    bus_read(12'h030, d); check("R13 data kept", d, 32'h0F0F_0F0F);
    bus_read(12'h004, d); check("R13 div kept", d, 32'h0);
    bus_read(12'h300, d); check("R13 prot kept", d, 32'h4);
    bus_read(12'h008, d); check("R13 ctrl kept", d, 32'h2000_0010);
  endtask

  task automatic t_bad_seq();
    int n;
    bus_write(12'h000, 32'h0D0);
    bus_write(12'h030, 32'h0);
    start_op(32'h2000_0003, n);
    check("R14 two starts", 32'(n), 32'h0);
    check_fault("R14 two starts fault", 1'b1);
    clear_fault();
    start_op(32'h2800_0011, n);
    check("R14 both widths", 32'(n), 32'h0);
    check_fault("R14 both widths fault", 1'b1);
    clear_fault();
    start_op(32'h2000_0001, n);
    check("R14 no width", 32'(n), 32'h0);
    check_word("R14 unchanged", 52);
    check_fault("R14 no width fault", 1'b1);
    clear_fault();
  endtask

  task automatic t_mass();
    int n;
    bus_write(12'h300, 32'h0);
    start_op(32'h2000_AA02, n);
    check("R10 mass pending", 32'(n), 32'(TICKS));
    for (int w = 0; w < WORDS; w++) begin
      model[w] = '1;
      check_word("R10 mass erased", w);
    end
  endtask

  initial begin
    for (int w = 0; w < WORDS; w++) model[w] = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_prog32();
    t_prog128();
    t_page_erase();
    t_qual();
    t_locked();
    t_protect();
    t_busy_ignore();
    t_bad_seq();
    t_mass();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule